// File: doc/BRIEF.md
# Dual Wiper Register Command Executor

This block carries out already-decoded commands for a pair of digitally controlled potentiometer channels. Each channel owns one volatile wiper position and a small bank of data registers that model nonvolatile storage. A serial bus front end hands over the command byte and, when the command carries one, the data byte. It does so with a one-cycle `cmd_valid` pulse at the stop condition that ends the command. The executor then reads or writes a wiper or a data register, moves values between a wiper and a data register on one channel or on both at once, or enters a stepping mode. In stepping mode each `step_valid` pulse moves the selected wiper one position up or down.

Any change to a data register starts a modelled nonvolatile write period. `busy` is held for a parameterised number of clock cycles, and new commands are dropped while it is set, as a front end would drop them by withholding acknowledge. When the write-protect input is low, no data register can be changed, but the wipers can still be loaded. At reset every data register takes its parameterised initial content, and each wiper recalls register 0 of its own channel.

Top module: `wiper_cmd_exec`

## Requirements
- R1: After reset, `wiper0` equals channel 0 register 0 of `DR_INIT`, `wiper1` equals channel 1 register 0, and `busy` and `rd_valid` are low. Register r of channel c sits at bits [(c*4+r)*8 +: 8] of `DR_INIT`.
- R2: The command byte is decoded as follows. Bits [7:4] are the opcode, bits [3:2] select data register 0..3, and bit 0 selects channel 0 or 1. Bit 1 has no effect.
- R3: Opcode 1010 loads `cmd_data` into the selected wiper, visible in the cycle after the `cmd_valid` edge.
- R4: Opcode 1001 returns the selected wiper, and opcode 1011 returns the selected data register. Either one places the value on `rd_data` with `rd_valid` high for the cycle after the `cmd_valid` edge. `rd_valid` is low after every other command.
- R5: Opcode 1100 stores `cmd_data` into the selected data register. `busy` then stays high for exactly `NV_CYCLES` cycles, starting the cycle after the command.
- R6: Opcode 1101 copies the selected data register into its channel's wiper and does not set `busy`. Opcode 1110 copies the selected wiper into the selected data register and sets `busy`.
- R7: Opcode 0001 loads both wipers from register index [3:2] of their own channel. Opcode 1000 stores both wipers into register index [3:2] of their own channel and sets `busy`.
- R8: While `wp_n` is low, opcodes 1100, 1110 and 1000 change no data register and leave `busy` low. Wiper loads (1010, 1101, 0001) still take effect.
- R9: A command presented while `busy` is high has no effect on wipers, registers or `rd_valid`.
- R10: Opcode 0010 enters stepping mode on the channel given by bit 0. Each `step_valid` pulse then moves that wiper by +1 if `step_up` is high and by -1 otherwise. The wiper holds at FFh going up and at 00h going down. The next accepted defined command ends stepping mode.
- R11: Opcodes not listed above change no state and do not end stepping mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on recall) |
| cmd_valid | input | 1 | One-cycle pulse: command complete at stop condition |
| cmd_byte | input | 8 | Instruction byte (opcode, register index, channel) |
| cmd_data | input | 8 | Data byte for write commands |
| step_valid | input | 1 | One step request in stepping mode |
| step_up | input | 1 | Step direction: 1 toward FFh, 0 toward 00h |
| wp_n | input | 1 | Write protect, low blocks data register changes |
| wiper0 | output | 8 | Channel 0 wiper position |
| wiper1 | output | 8 | Channel 1 wiper position |
| busy | output | 1 | Nonvolatile write period in progress |
| rd_data | output | 8 | Last value read |
| rd_valid | output | 1 | `rd_data` updated this cycle |

## Verification
The bench tests saturation at both ends of the wiper range. A design without clamping would wrap FFh to 00h or 00h to FFh. It checks that a wiper write issued during the busy window is dropped. A design without this drop would move the wiper during a pending store. It also checks that write protect blocks all three register-modifying opcodes and still lets wiper loads through. A design with this gating inverted would either corrupt stored settings or freeze the wipers. The last group covers the global transfers, the ignored reserved bit, and the end of stepping mode on the next command. Errors here would show up as a channel loaded from the wrong bank index, a mis-decoded opcode, or steps still being applied after a new command.

// File: rtl/wce_pkg.sv
package wce_pkg;
   typedef enum logic [3:0] {
      OP_GDR2W = 4'h1,
      OP_STEP  = 4'h2,
      OP_GW2DR = 4'h8,
      OP_RDW   = 4'h9,
      OP_WRW   = 4'hA,
      OP_RDDR  = 4'hB,
      OP_WRDR  = 4'hC,
      OP_DR2W  = 4'hD,
      OP_W2DR  = 4'hE
   } wce_op_e;
endpackage

// File: rtl/wce_nv_timer.sv
module wce_nv_timer #(
   parameter int unsigned CYCLES = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned CW = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad
         $error("wce_nv_timer: CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   // R5: busy only begins on a store start
   p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: rtl/wce_channel.sv
module wce_channel #(
   parameter int unsigned W    = 8,
   parameter int unsigned NREG = 4,
   parameter int unsigned IW   = $clog2(NREG),
   parameter logic [NREG*W-1:0] INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_wiper,
   input  logic [W-1:0]  ld_val,
   input  logic          wr_dr,
   input  logic [IW-1:0] dr_idx,
   input  logic [W-1:0]  dr_val,
   input  logic          step_en,
   input  logic          step_up,
   output logic [W-1:0]  wiper,
   output logic [W-1:0]  dr_rd
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] dr_q [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < int'(NREG); r++)
            dr_q[r] <= INIT[r*W +: W];
         wiper <= INIT[W-1:0];
      end else begin
         if (wr_dr)
            dr_q[dr_idx] <= dr_val;
         if (ld_wiper)
            wiper <= ld_val;
         else if (step_en) begin
            if (step_up && wiper != TOP)
               wiper <= wiper + 1'b1;
            else if (!step_up && wiper != '0)
               wiper <= wiper - 1'b1;
         end
      end
   end

   assign dr_rd = dr_q[dr_idx];

   // R10: clamp at both ends
   p_sat_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ld_wiper && step_up && wiper == TOP) |=> wiper == TOP);
   p_sat_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ld_wiper && !step_up && wiper == '0) |=> wiper == '0);
   // R10: single-position move
   p_step_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ld_wiper && step_up && wiper != TOP) |=> wiper == $past(wiper) + 1'b1);
endmodule

// File: rtl/wiper_cmd_exec.sv
module wiper_cmd_exec
   import wce_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter int unsigned NREG      = 4,
   parameter int unsigned NV_CYCLES = 1000000,
   parameter logic [2*NREG*W-1:0] DR_INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmd_valid,
   input  logic [7:0]   cmd_byte,
   input  logic [W-1:0] cmd_data,
   input  logic         step_valid,
   input  logic         step_up,
   input  logic         wp_n,
   output logic [W-1:0] wiper0,
   output logic [W-1:0] wiper1,
   output logic         busy,
   output logic [W-1:0] rd_data,
   output logic         rd_valid
);
   localparam int unsigned NCH = 2;
   localparam int unsigned IW  = $clog2(NREG);

   generate
      if (IW < 1 || IW > 2 || (1 << IW) != NREG) begin : g_bad_nreg
         $error("wiper_cmd_exec: NREG must be 2 or 4");
      end
      if (W < 1) begin : g_bad_w
         $error("wiper_cmd_exec: W must be positive");
      end
   endgenerate

   logic [3:0]    op;
   logic [IW-1:0] idx;
   logic          sel;
   logic          go, known, dr_ok;
   logic          unused_rsvd;
   logic          step_act_q, step_ch_q;
   logic          nv_start;
   logic [W-1:0]  wip  [NCH];
   logic [W-1:0]  drv  [NCH];
   logic          ldw  [NCH];
   logic [W-1:0]  ldv  [NCH];
   logic          wrd  [NCH];
   logic [W-1:0]  wrv  [NCH];
   logic          sten [NCH];

   assign op          = cmd_byte[7:4];
   assign idx         = cmd_byte[2 +: IW];
   assign sel         = cmd_byte[0];
   assign unused_rsvd = cmd_byte[1];
   assign go          = cmd_valid && !busy;
   assign dr_ok       = wp_n;

   always_comb begin
      case (op)
         OP_GDR2W, OP_STEP, OP_GW2DR, OP_RDW, OP_WRW,
         OP_RDDR, OP_WRDR, OP_DR2W, OP_W2DR: known = 1'b1;
         default:                            known = 1'b0;
      endcase
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         localparam logic CH = c[0];
         always_comb begin
            ldw[c] = 1'b0;
            ldv[c] = cmd_data;
            wrd[c] = 1'b0;
            wrv[c] = cmd_data;
            if (go) begin
               case (op)
                  OP_WRW:   ldw[c] = (sel == CH);
                  OP_DR2W:  begin ldw[c] = (sel == CH); ldv[c] = drv[c]; end
                  OP_GDR2W: begin ldw[c] = 1'b1;        ldv[c] = drv[c]; end
                  OP_WRDR:  wrd[c] = dr_ok && (sel == CH);
                  OP_W2DR:  begin wrd[c] = dr_ok && (sel == CH); wrv[c] = wip[c]; end
                  OP_GW2DR: begin wrd[c] = dr_ok;               wrv[c] = wip[c]; end
                  default:  ;
               endcase
            end
         end
         assign sten[c] = step_act_q && (step_ch_q == CH) && step_valid && !busy && !go;

         wce_channel #(
            .W(W), .NREG(NREG), .IW(IW),
            .INIT(DR_INIT[c*NREG*W +: NREG*W])
         ) u_ch (
            .clk(clk), .rst_n(rst_n),
            .ld_wiper(ldw[c]), .ld_val(ldv[c]),
            .wr_dr(wrd[c]), .dr_idx(idx), .dr_val(wrv[c]),
            .step_en(sten[c]), .step_up(step_up),
            .wiper(wip[c]), .dr_rd(drv[c])
         );
      end
   endgenerate

   assign nv_start = wrd[0] || wrd[1];

   wce_nv_timer #(.CYCLES(NV_CYCLES)) u_nv (
      .clk(clk), .rst_n(rst_n), .start(nv_start), .busy(busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_act_q <= 1'b0;
         step_ch_q  <= 1'b0;
         rd_data    <= '0;
         rd_valid   <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         if (go && known) begin
            step_act_q <= (op == OP_STEP);
            step_ch_q  <= sel;
            if (op == OP_RDW) begin
               rd_data  <= sel ? wip[1] : wip[0];
               rd_valid <= 1'b1;
            end else if (op == OP_RDDR) begin
               rd_data  <= sel ? drv[1] : drv[0];
               rd_valid <= 1'b1;
            end
         end
      end
   end

   assign wiper0 = wip[0];
   assign wiper1 = wip[1];

   // R9: commands during a store are dropped
   p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> ($stable(wiper0) && $stable(wiper1) && !rd_valid));
   // R8: protected stores never start the timer
   p_wp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && !wp_n) |=> !busy);
   // R4: read strobe only follows an accepted command
   p_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(cmd_valid && !busy));
endmodule

// File: tb/wiper_cmd_exec_tb.sv
module wiper_cmd_exec_tb;
   localparam int NV = 20;
   localparam logic [63:0] INIT = 64'h88776655_44332211;

   logic       clk = 0, rst_n = 0;
   logic       cmd_valid = 0, step_valid = 0, step_up = 0, wp_n = 1;
   logic [7:0] cmd_byte = 0, cmd_data = 0;
   logic [7:0] wiper0, wiper1, rd_data;
   logic       busy, rd_valid;

   int vectors = 0, fails = 0, cyc = 0;

   always #2.5 clk = ~clk;

   wiper_cmd_exec #(.W(8), .NREG(4), .NV_CYCLES(NV), .DR_INIT(INIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .cmd_data(cmd_data), .step_valid(step_valid), .step_up(step_up),
      .wp_n(wp_n), .wiper0(wiper0), .wiper1(wiper1), .busy(busy),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // behavioural reference
   int mdr [2][4];
   int mw [2];
   int mcnt, mrd, mrdv, mch;
   bit mstep;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++)
            for (int r = 0; r < 4; r++) mdr[c][r] = (INIT >> ((c*4+r)*8)) & 8'hFF;
         mw[0] = mdr[0][0]; mw[1] = mdr[1][0];
         mcnt = 0; mrd = 0; mrdv = 0; mstep = 0; mch = 0;
      end else begin
         automatic bit go = cmd_valid && mcnt == 0;
         automatic int op = cmd_byte[7:4];
         automatic int ch = cmd_byte[0];
         automatic int ix = cmd_byte[3:2];
         automatic bit st = 0;
         automatic bit dostep = !go && mstep && step_valid && mcnt == 0;
         mrdv = 0;
         if (go) begin
            case (op)
               4'h9: begin mrd = mw[ch]; mrdv = 1; end
               4'hB: begin mrd = mdr[ch][ix]; mrdv = 1; end
               4'hA: mw[ch] = cmd_data;
               4'hD: mw[ch] = mdr[ch][ix];
               4'h1: begin mw[0] = mdr[0][ix]; mw[1] = mdr[1][ix]; end
               4'hC: if (wp_n) begin mdr[ch][ix] = cmd_data; st = 1; end
               4'hE: if (wp_n) begin mdr[ch][ix] = mw[ch]; st = 1; end
               4'h8: if (wp_n) begin mdr[0][ix] = mw[0]; mdr[1][ix] = mw[1]; st = 1; end
               default: ;
            endcase
            if (op inside {1, 2, 8, 9, 10, 11, 12, 13, 14}) begin
               mstep = (op == 2); mch = ch;
            end
         end
         if (dostep) begin
            if (step_up && mw[mch] < 255) mw[mch]++;
            else if (!step_up && mw[mch] > 0) mw[mch]--;
         end
         if (st) mcnt = NV; else if (mcnt > 0) mcnt--;
      end
   end

   always @(negedge clk) if (rst_n) begin
      vectors++;
      if (wiper0 !== 8'(mw[0]) || wiper1 !== 8'(mw[1])) begin
         fails++;
         $display("FAIL R3 model wipers act %h/%h exp %h/%h", wiper0, wiper1, mw[0], mw[1]);
      end
      if (busy !== (mcnt != 0)) begin
         fails++;
         $display("FAIL R5 model busy act %b exp %b", busy, mcnt != 0);
      end
      if (rd_valid !== mrdv[0] || (mrdv && rd_data !== 8'(mrd))) begin
         fails++;
         $display("FAIL R4 model read act %b/%h exp %b/%h", rd_valid, rd_data, mrdv[0], mrd);
      end
   end

   task automatic chk(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act %h exp %h", tag, act, exp);
      end
   endtask

   task automatic cmd(logic [7:0] b, logic [7:0] d);
      @(negedge clk);
      cmd_byte = b; cmd_data = d; cmd_valid = 1;
      @(negedge clk);
      cmd_valid = 0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic step(logic up, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         step_up = up; step_valid = 1;
         @(negedge clk);
         step_valid = 0;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 wiper0", wiper0, 8'h11);
      chk("R1 wiper1", wiper1, 8'h55);
      chk("R1 busy", busy, 0);
      chk("R1 rd_valid", rd_valid, 0);

      cmd(8'hA1, 8'h3C);
      chk("R3 wiper1 write", wiper1, 8'h3C);
      cmd(8'h90, 8'h00);
      chk("R4 read wiper0", rd_data, 8'h11);
      chk("R4 rd_valid", rd_valid, 1);
      cmd(8'hB9, 8'h00);
      chk("R4 read dr2 ch1", rd_data, 8'h77);

      cmd(8'hC4, 8'hA5);
      chk("R5 busy set", busy, 1);
      begin
         int n = 1;
         cmd(8'hA0, 8'hFF);
         n += 2;
         chk("R9 wiper0 unchanged", wiper0, 8'h11);
         while (busy) begin @(negedge clk); n++; end
         chk("R5 busy length", n - 1, NV);
      end
      cmd(8'hB4, 8'h00);
      chk("R5 dr1 ch0 stored", rd_data, 8'hA5);

      wp_n = 0;
      cmd(8'hC8, 8'h00);
      chk("R8 no busy", busy, 0);
      cmd(8'hB8, 8'h00);
      chk("R8 dr2 ch0 kept", rd_data, 8'h33);
      cmd(8'hA0, 8'h80);
      chk("R8 wiper write under wp", wiper0, 8'h80);
      cmd(8'hE0, 8'h00);
      chk("R8 w2dr blocked busy", busy, 0);
      wp_n = 1;

      cmd(8'hD5, 8'h00);
      chk("R6 dr1 ch1 to wiper1", wiper1, 8'h66);
      chk("R6 no busy", busy, 0);
      cmd(8'hEC, 8'h00);
      chk("R6 w2dr busy", busy, 1);
      wait_idle();
      cmd(8'hBC, 8'h00);
      chk("R6 dr3 ch0", rd_data, 8'h80);

      cmd(8'h18, 8'h00);
      chk("R7 global wiper0", wiper0, 8'h33);
      chk("R7 global wiper1", wiper1, 8'h77);
      cmd(8'hA0, 8'h01);
      cmd(8'hA1, 8'hFE);
      cmd(8'h80, 8'h00);
      chk("R7 global store busy", busy, 1);
      wait_idle();
      cmd(8'hB0, 8'h00);
      chk("R7 dr0 ch0", rd_data, 8'h01);
      cmd(8'hB1, 8'h00);
      chk("R7 dr0 ch1", rd_data, 8'hFE);

      cmd(8'h21, 8'h00);
      step(1, 3);
      chk("R10 saturate high", wiper1, 8'hFF);
      chk("R10 other channel", wiper0, 8'h01);
      cmd(8'h20, 8'h00);
      step(0, 3);
      chk("R10 saturate low", wiper0, 8'h00);
      step(1, 1);
      chk("R10 single step", wiper0, 8'h01);

      cmd(8'h30, 8'h00);
      step(1, 1);
      chk("R11 undefined keeps stepping", wiper0, 8'h02);
      chk("R11 no read", rd_valid, 0);

      cmd(8'hA2, 8'h42);
      chk("R2 reserved bit ignored", wiper0, 8'h42);
      step(1, 2);
      chk("R10 stepping ended", wiper0, 8'h42);

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule